// File: doc/BRIEF.md
# Phase-Absolute Profile Oscillator

This block is one complex tone source inside a pulse generator. Every sample clock it emits one I/Q sample, each part a 16-bit signed value. The tone's frequency, phase offset and amplitude come from a bank of 32 profiles. A host fills that bank one entry at a time through a plain write port. A trigger pulse with a profile index switches the oscillator to that profile, and the switch lands on the sample of the trigger cycle.

The phase is not built up by an accumulator. A free-running sample counter starts at zero when reset is released. Each sample's phase is the active frequency word times that count, plus the offset, modulo one turn. So the phase depends only on the active profile and on time. Leaving a profile and coming back to it later gives the same phase as if it had never been left.

A quarter-wave sine table turns the phase into sine and cosine. The amplitude then scales both, and the result is rounded back to 16 bits. The output is registered, and a valid strobe is aligned with the data.

Top module: `absphase_osc`

## Requirements
- R1: While `rst_n` is low, `out_valid_o` is 0 and both outputs are 0. Reset clears every profile entry and the active profile to all zeros. Until the first trigger, every output sample is exactly 0.
- R2: The reset release passes through a two-flop synchronizer, and the data path has three register stages. `out_valid_o` first reads 1 after the 5th rising clock edge following the release of `rst_n`. It then stays 1, and the n-th valid output (counting from 0) is sample n.
- R3: The 32-bit phase of sample t is (F·t + P·2^16) mod 2^32. Here t counts samples from 0 at reset release, and F and P are the frequency word and phase offset of the profile active for that sample.
- R4: Let n be bits [31:24] of the phase, C = round(32767·cos(2π(n+0.5)/256)) and S = round(32767·sin(2π(n+0.5)/256)). Then I = floor((A·C + 32768)/65536) and Q = floor((A·S + 32768)/65536), where A is the unsigned amplitude. The table rounding may differ by at most 1 LSB.
- R5: A trigger with index k makes profile k active from the sample of the trigger cycle onward. Without a trigger, the active profile stays the same.
- R6: Returning to a profile gives exactly the phase F·t + P·2^16 of that profile. Nothing is carried over from the profiles used in between.
- R7: A profile with amplitude 0 produces exactly I = 0 and Q = 0, whatever its frequency and phase offset.
- R8: A write stores the whole entry {freq, phase offset, amp} at the given index. It does not change the active profile until a trigger selects that entry.
- R9: If a write and a trigger address the same entry in the same cycle, the trigger uses the entry's previous contents. The new contents take effect only at a later trigger.
- R10: Triggers on consecutive cycles each take effect on their own sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_wr_i | input | 1 | Profile write strobe |
| prof_waddr_i | input | 5 | Profile index to write |
| prof_freq_i | input | 32 | Frequency word, full scale = one turn per sample |
| prof_poff_i | input | 16 | Phase offset, full scale = one turn |
| prof_amp_i | input | 16 | Unsigned amplitude |
| trig_i | input | 1 | Make the selected profile active on this cycle's sample |
| trig_sel_i | input | 5 | Profile index for the trigger |
| out_i_o | output | 16 | In-phase sample, signed |
| out_q_o | output | 16 | Quadrature sample, signed |
| out_valid_o | output | 1 | Output sample valid |

## Verification
A profile write and a trigger can land in the same cycle on the same entry. The bench provokes this by rewriting the entry that the trigger selects in that very cycle. It then expects the old contents at the output for the following samples, and the new contents only after a second trigger. Triggers on back-to-back cycles are also driven, rotating through four entries. Every sample is compared against a reference model that records which profile snapshot applies from which sample index onward.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int FREQ_W  = 32;
  localparam int PHOFF_W = 16;
  localparam int AMP_W   = 16;
  localparam int SAMP_W  = 16;
  localparam int TIME_W  = FREQ_W;

  typedef struct packed {
    logic [FREQ_W-1:0]  freq;
    logic [PHOFF_W-1:0] poff;
    logic [AMP_W-1:0]   amp;
  } prof_t;

  localparam int PROF_W = $bits(prof_t);
endpackage

// File: rtl/osc_profile_bank.sv
module osc_profile_bank
  import osc_pkg::*;
#(
  parameter  int NPROF = 32,
  localparam int AW    = $clog2(NPROF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  prof_t         wr_data_i,
  input  logic          trig_i,
  input  logic [AW-1:0] trig_sel_i,
  output prof_t         eff_o
);

  prof_t bank_q [NPROF];
  prof_t act_q;
  prof_t act_d;
  prof_t sel_prof;

  // storage: one entry updated per write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NPROF; e++) bank_q[e] <= '0;
    end else if (wr_en_i) begin
      bank_q[wr_addr_i] <= wr_data_i;
    end
  end

  // a trigger reads the entry before this cycle's write lands
  always_comb begin
    sel_prof = bank_q[trig_sel_i];
    act_d    = trig_i ? sel_prof : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign eff_o = act_d;

  // R8
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i |=> act_q == $past(act_q));

  // R9
  same_cycle_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && wr_en_i && (wr_addr_i == trig_sel_i) |=> act_q == $past(bank_q[trig_sel_i]));

endmodule

// File: rtl/osc_phase_gen.sv
module osc_phase_gen
  import osc_pkg::*;
#(
  parameter int LUT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  prof_t               eff_i,
  output logic [LUT_BITS-1:0] lut_idx_o,
  output logic [AMP_W-1:0]    amp_o,
  output logic                vld_o
);

  logic [TIME_W-1:0] t_q, t_d;
  logic [FREQ_W-1:0] ph_q, ph_d;
  logic [AMP_W-1:0]  amp_q, amp_d;
  logic              vld_q, vld_d;

  always_comb begin
    t_d   = t_q + 1'b1;
    ph_d  = eff_i.freq * t_q + {eff_i.poff, {(FREQ_W-PHOFF_W){1'b0}}};
    amp_d = eff_i.amp;
    vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q   <= '0;
      ph_q  <= '0;
      amp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      t_q   <= t_d;
      ph_q  <= ph_d;
      amp_q <= amp_d;
      vld_q <= vld_d;
    end
  end

  assign lut_idx_o = ph_q[FREQ_W-1 -: LUT_BITS];
  assign amp_o     = amp_q;
  assign vld_o     = vld_q;

  logic unused_ph_lo;
  assign unused_ph_lo = ^ph_q[FREQ_W-LUT_BITS-1:0];

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && $stable(eff_i) |=> (ph_q - $past(ph_q)) == $past(eff_i.freq));

  // R3
  phase_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> ph_q == {$past(eff_i.poff), {(FREQ_W-PHOFF_W){1'b0}}});

endmodule

// File: rtl/osc_quarter_sine.sv
module osc_quarter_sine
  import osc_pkg::*;
#(
  parameter  int LUT_BITS = 8,
  localparam int QB       = LUT_BITS - 2,
  localparam int QN       = 1 << QB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LUT_BITS-1:0]      idx_i,
  input  logic [AMP_W-1:0]         amp_i,
  input  logic                     vld_i,
  output logic signed [SAMP_W-1:0] sin_o,
  output logic signed [SAMP_W-1:0] cos_o,
  output logic [AMP_W-1:0]         amp_o,
  output logic                     vld_o
);

  localparam longint AMAX = (longint'(1) <<< (SAMP_W-1)) - 1;

  // sine of a bin midpoint, Taylor series in Q30 fixed point
  function automatic logic [SAMP_W-1:0] qsin(input int j);
    longint x, x2, term, acc;
    x    = (longint'(1686629713) * longint'(2*j + 1)) >>> (QB + 1);
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -((term * x2) >>> 30) / longint'((2*n) * (2*n + 1));
      acc  = acc + term;
    end
    return SAMP_W'((acc * AMAX + (longint'(1) <<< 29)) >>> 30);
  endfunction

  logic [QN-1:0][SAMP_W-1:0] rom;
  for (genvar j = 0; j < QN; j++) begin : g_rom
    assign rom[j] = qsin(j);
  end

  logic [1:0][LUT_BITS-1:0] idx_ch;
  logic [1:0][SAMP_W-1:0]   val_ch;
  assign idx_ch[0] = idx_i;
  assign idx_ch[1] = idx_i + LUT_BITS'(QN);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0]               quad;
    logic [QB-1:0]            pos;
    logic [QB-1:0]            addr;
    logic signed [SAMP_W-1:0] mag;
    assign quad = idx_ch[c][LUT_BITS-1 -: 2];
    assign pos  = idx_ch[c][QB-1:0];
    assign addr = quad[0] ? ~pos : pos;
    assign mag  = $signed(rom[addr]);
    assign val_ch[c] = quad[1] ? -mag : mag;
  end

  logic signed [SAMP_W-1:0] sin_d, cos_d;
  always_comb begin
    sin_d = $signed(val_ch[0]);
    cos_d = $signed(val_ch[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
      amp_o <= '0;
      vld_o <= 1'b0;
    end else begin
      sin_o <= sin_d;
      cos_o <= cos_d;
      amp_o <= amp_i;
      vld_o <= vld_i;
    end
  end

  // R4
  sym_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (sin_o != -(2**(SAMP_W-1))) && (cos_o != -(2**(SAMP_W-1))));

endmodule

// File: rtl/osc_amp_scale.sv
module osc_amp_scale
  import osc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic [AMP_W-1:0]         amp_i,
  input  logic signed [SAMP_W-1:0] sin_i,
  input  logic signed [SAMP_W-1:0] cos_i,
  output logic signed [SAMP_W-1:0] i_o,
  output logic signed [SAMP_W-1:0] q_o,
  output logic                     vld_o
);

  localparam int PW = AMP_W + SAMP_W + 1;

  logic signed [PW-1:0] prod_i, prod_q, rnd_i, rnd_q;
  logic signed [SAMP_W-1:0] i_d, q_d;

  always_comb begin
    prod_i = $signed({1'b0, amp_i}) * cos_i;
    prod_q = $signed({1'b0, amp_i}) * sin_i;
    rnd_i  = prod_i + (PW'(1) <<< (AMP_W-1));
    rnd_q  = prod_q + (PW'(1) <<< (AMP_W-1));
    i_d    = rnd_i[AMP_W +: SAMP_W];
    q_d    = rnd_q[AMP_W +: SAMP_W];
  end

  logic unused_rnd;
  assign unused_rnd = ^{rnd_i[PW-1], rnd_i[AMP_W-1:0], rnd_q[PW-1], rnd_q[AMP_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_o   <= '0;
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      i_o   <= i_d;
      q_o   <= q_d;
      vld_o <= vld_i;
    end
  end

  // R7
  zero_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && (amp_i == '0) |=> (i_o == '0) && (q_o == '0));

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> vld_o);

endmodule

// File: rtl/absphase_osc.sv
module absphase_osc
  import osc_pkg::*;
#(
  parameter  int NPROF    = 32,
  parameter  int LUT_BITS = 8,
  localparam int AW       = $clog2(NPROF)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prof_wr_i,
  input  logic [AW-1:0]            prof_waddr_i,
  input  logic [FREQ_W-1:0]        prof_freq_i,
  input  logic [PHOFF_W-1:0]       prof_poff_i,
  input  logic [AMP_W-1:0]         prof_amp_i,
  input  logic                     trig_i,
  input  logic [AW-1:0]            trig_sel_i,
  output logic signed [SAMP_W-1:0] out_i_o,
  output logic signed [SAMP_W-1:0] out_q_o,
  output logic                     out_valid_o
);

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  prof_t wr_data, eff;
  assign wr_data = '{freq: prof_freq_i, poff: prof_poff_i, amp: prof_amp_i};

  osc_profile_bank #(.NPROF(NPROF)) u_bank (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (prof_wr_i),
    .wr_addr_i  (prof_waddr_i),
    .wr_data_i  (wr_data),
    .trig_i     (trig_i),
    .trig_sel_i (trig_sel_i),
    .eff_o      (eff)
  );

  logic [LUT_BITS-1:0] s1_idx;
  logic [AMP_W-1:0]    s1_amp;
  logic                s1_vld;

  osc_phase_gen #(.LUT_BITS(LUT_BITS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .eff_i     (eff),
    .lut_idx_o (s1_idx),
    .amp_o     (s1_amp),
    .vld_o     (s1_vld)
  );

  logic signed [SAMP_W-1:0] s2_sin, s2_cos;
  logic [AMP_W-1:0]         s2_amp;
  logic                     s2_vld;

  osc_quarter_sine #(.LUT_BITS(LUT_BITS)) u_lut (
    .clk   (clk),
    .rst_n (rst_int_n),
    .idx_i (s1_idx),
    .amp_i (s1_amp),
    .vld_i (s1_vld),
    .sin_o (s2_sin),
    .cos_o (s2_cos),
    .amp_o (s2_amp),
    .vld_o (s2_vld)
  );

  osc_amp_scale u_scale (
    .clk   (clk),
    .rst_n (rst_int_n),
    .vld_i (s2_vld),
    .amp_i (s2_amp),
    .sin_i (s2_sin),
    .cos_i (s2_cos),
    .i_o   (out_i_o),
    .q_o   (out_q_o),
    .vld_o (out_valid_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid_o && (out_i_o == '0) && (out_q_o == '0));

endmodule

// File: tb/sim_absphase_osc.sv
module sim_absphase_osc;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n;
  logic               prof_wr;
  logic [4:0]         waddr;
  logic [31:0]        freq;
  logic [15:0]        poff;
  logic [15:0]        amp;
  logic               trig;
  logic [4:0]         tsel;
  logic signed [15:0] out_i, out_q;
  logic               out_valid;

  absphase_osc u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .prof_wr_i    (prof_wr),
    .prof_waddr_i (waddr),
    .prof_freq_i  (freq),
    .prof_poff_i  (poff),
    .prof_amp_i   (amp),
    .trig_i       (trig),
    .trig_sel_i   (tsel),
    .out_i_o      (out_i),
    .out_q_o      (out_q),
    .out_valid_o  (out_valid)
  );

  int n_run  = 0;
  int n_fail = 0;
  string req = "R1";
  longint k = 0;
  bit started = 0;
  logic [63:0] mem_m [32];
  logic [63:0] act_m = '0;
  longint pq_idx [$];
  logic [63:0] pq_val [$];

  // vector: {index, freq, phase offset, amp, hold cycles}
  localparam int NV = 6;
  localparam logic [76:0] VEC [NV] = '{
    {5'd1,  32'h0100_0000, 16'h0000, 16'hFFFF, 8'd20},
    {5'd2,  32'h0400_0000, 16'h4000, 16'h8000, 8'd12},
    {5'd7,  32'hFC00_0000, 16'h8000, 16'hC000, 8'd12},
    {5'd31, 32'h0000_0000, 16'h2000, 16'hFFFF, 8'd6},
    {5'd16, 32'h1234_5678, 16'hABCD, 16'h7FFF, 8'd16},
    {5'd9,  32'h8000_0000, 16'h0000, 16'h4000, 8'd6}
  };

  task automatic chk(input string r, input bit ok, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic longint rnd(input real x);
    return (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(-x + 0.5));
  endfunction

  function automatic void calc(input longint t, input logic [63:0] pv,
                               output longint ei, output longint eq);
    logic [31:0] f, ph;
    logic [15:0] p, a;
    int n;
    real ang;
    longint c, s;
    f   = pv[63:32];
    p   = pv[31:16];
    a   = pv[15:0];
    ph  = 32'((longint'(f) * t) + longint'({p, 16'h0000}));
    n   = int'(ph[31:24]);
    ang = 2.0 * 3.14159265358979 * (real'(n) + 0.5) / 256.0;
    c   = rnd(32767.0 * $cos(ang));
    s   = rnd(32767.0 * $sin(ang));
    ei  = (longint'(a) * c + 32768) >>> 16;
    eq  = (longint'(a) * s + 32768) >>> 16;
  endfunction

  task automatic observe();
    longint ei, eq, di, dq;
    bit ok_i, ok_q;
    if (started) chk("R2", out_valid == 1'b1, longint'(out_valid), 1);
    if (out_valid) begin
      started = 1;
      while (pq_idx.size() > 0 && pq_idx[0] <= k) begin
        act_m = pq_val.pop_front();
        void'(pq_idx.pop_front());
      end
      calc(k, act_m, ei, eq);
      di = longint'(out_i) - ei;
      dq = longint'(out_q) - eq;
      if (act_m[15:0] == 16'h0000) begin
        // R7 / R1: exact silence
        ok_i = (out_i == 0);
        ok_q = (out_q == 0);
      end else begin
        ok_i = (di >= -2) && (di <= 2);
        ok_q = (dq >= -2) && (dq <= 2);
      end
      chk(req, ok_i, longint'(out_i), ei);
      chk(req, ok_q, longint'(out_q), eq);
      k++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    observe();
  endtask

  task automatic cyc(input bit tg, input logic [4:0] ts, input bit w,
                     input logic [4:0] wa, input logic [63:0] wv);
    trig    = tg;
    tsel    = ts;
    prof_wr = w;
    waddr   = wa;
    {freq, poff, amp} = wv;
    if (tg) begin
      pq_idx.push_back(k + 2);
      pq_val.push_back(mem_m[ts]);
    end
    if (w) mem_m[wa] = wv;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'd0, 1'b0, 5'd0, 64'd0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int w;
    for (int e = 0; e < 32; e++) mem_m[e] = '0;
    rst_n = 1'b0; prof_wr = 0; waddr = 0; freq = 0; poff = 0; amp = 0; trig = 0; tsel = 0;
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    chk("R1", out_valid == 1'b0, longint'(out_valid), 0);
    chk("R1", out_i == 0, longint'(out_i), 0);
    chk("R1", out_q == 0, longint'(out_q), 0);
    rst_n = 1'b1;
    // R2: first valid after the 5th rising edge
    w = 0;
    do begin step(); w++; end while (!out_valid && w < 20);
    chk("R2", w == 5, w, 5);
    req = "R1";
    idle(6);

    // vector table: write, trigger, hold
    for (int v = 0; v < NV; v++) begin
      req = (v < 3) ? "R3" : "R4";
      cyc(1'b0, 5'd0, 1'b1, VEC[v][76:72], VEC[v][71:8]);
      cyc(1'b1, VEC[v][76:72], 1'b0, 5'd0, 64'd0);
      idle(int'(VEC[v][7:0]));
    end

    // R5: switch lands on the trigger's own sample
    req = "R5";
    cyc(1'b1, 5'd1, 1'b0, 5'd0, 64'd0);
    idle(3);
    cyc(1'b1, 5'd7, 1'b0, 5'd0, 64'd0);
    idle(6);

    // R6: leave a profile and return
    req = "R6";
    cyc(1'b1, 5'd1, 1'b0, 5'd0, 64'd0);
    idle(6);
    cyc(1'b1, 5'd16, 1'b0, 5'd0, 64'd0);
    idle(7);
    cyc(1'b1, 5'd1, 1'b0, 5'd0, 64'd0);
    idle(8);

    // R9: write and trigger the same entry together
    req = "R9";
    cyc(1'b1, 5'd2, 1'b1, 5'd2, {32'h0200_0000, 16'h1000, 16'hA000});
    idle(5);
    cyc(1'b1, 5'd2, 1'b0, 5'd0, 64'd0);
    idle(6);

    // R8: rewrite the active entry without trigger, then reveal it
    req = "R8";
    cyc(1'b0, 5'd0, 1'b1, 5'd2, {32'h0C00_0000, 16'h6000, 16'hF000});
    idle(6);
    cyc(1'b1, 5'd2, 1'b0, 5'd0, 64'd0);
    idle(6);

    // R7: zero amplitude is silence
    req = "R7";
    cyc(1'b0, 5'd0, 1'b1, 5'd5, {32'h0777_7777, 16'h1234, 16'h0000});
    cyc(1'b1, 5'd5, 1'b0, 5'd0, 64'd0);
    idle(8);
    cyc(1'b1, 5'd0, 1'b0, 5'd0, 64'd0);
    idle(4);

    // R10: a trigger on every cycle
    req = "R10";
    for (int i = 0; i < 8; i++) begin
      logic [4:0] ent;
      case (i % 4)
        0: ent = 5'd1;
        1: ent = 5'd7;
        2: ent = 5'd16;
        default: ent = 5'd9;
      endcase
      cyc(1'b1, ent, 1'b0, 5'd0, 64'd0);
    end
    idle(8);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule